// File: doc/BRIEF.md
# Non-Maskable Interrupt Source Aggregator

This block gathers seven independent non-maskable interrupt sources into a single request line to the processor. It records which sources fired in a sticky cause register that software reads to find the culprit. Each source sets its cause bit on a rising edge. Software clears bits by writing 0 to them. The request line stays high while any cause bit remains set.

The sources are:
- an external active-high pin, which is asynchronous and goes through a two-flop synchroniser;
- an oscillator-check failure flag;
- a software request bit;
- a watchdog time-out, which counts only while the watchdog is configured for non-maskable operation;
- a tamper flag;
- an analog-supply brown-out flag;
- a digital-supply brown-out flag.

All sources except the pin are synchronous digital inputs.

The pin source is off after reset. Turning it on takes a guarded sequence. First a fixed key is written to the lock register. Then the commit bit is set. Only then is a write to the pin-enable register accepted.

Top module: `nmi_aggregator`

## Requirements
- R1: After reset the cause register reads 0, `nmi_o` is low, the lock register reads 1 (locked), and the commit and pin-enable registers read 0.
- R2: A rising edge on a synchronous source sets its cause bit at the next clock edge. The bit positions are: 1 oscillator failure, 2 software request, 3 watchdog, 4 tamper, 5 analog brown-out, 6 digital brown-out. A source held high after its bit was cleared does not set the bit again.
- R3: `nmi_o` is high exactly while at least one cause bit is set. It stays high until every bit has been cleared.
- R4: A write to register select 0 (cause) clears each cause bit whose write-data bit is 0 and leaves bits written with 1 unchanged.
- R5: When a source event and a clearing write hit the same bit in the same cycle, the bit ends up set.
- R6: A watchdog time-out edge sets cause bit 3 only while `wdt_nmi_mode_i` is 1.
- R7: The pin is active high and is synchronised by two flops. Once enabled, cause bit 0 sets on the third rising clock edge after the pin goes high. While pin-enable is 0 the pin has no effect.
- R8: Writing `UNLOCK_KEY` (default 32'hA5C3_1E7D) to register select 1 unlocks, and writing any other value relocks. A write to register select 2 (commit, data bit 0) takes effect only while unlocked.
- R9: A write to register select 3 (pin-enable, data bit 0) takes effect only while the commit bit is 1.
- R10: Reads return the register chosen by `reg_sel_i`: 0 gives the cause bits in [6:0]; 1 gives the locked flag in bit 0; 2 gives commit in bit 0; 3 gives pin-enable in bit 0. All other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| pin_async_i | input | 1 | External NMI pin, asynchronous, active high |
| osc_fail_i | input | 1 | Oscillator verification failure flag |
| sw_nmi_i | input | 1 | Software NMI request bit |
| wdt_timeout_i | input | 1 | Watchdog time-out flag |
| wdt_nmi_mode_i | input | 1 | Watchdog interrupt type selects NMI |
| tamper_i | input | 1 | Tamper event flag |
| bor_analog_i | input | 1 | Analog-supply brown-out comparator output |
| bor_digital_i | input | 1 | Digital-supply brown-out comparator output |
| reg_wr_i | input | 1 | Register write strobe |
| reg_sel_i | input | 2 | Register select |
| reg_wdata_i | input | DW | Register write data |
| reg_rdata_o | output | DW | Register read data, combinational from `reg_sel_i` |
| nmi_o | output | 1 | NMI request to the processor |

## Verification
Any fault in the cause state shows on the cause read and on `nmi_o` one edge after the source edge or the clearing write. The bench samples there rather than a cycle later, so a bit that is set late, lost, or set twice is caught. A fault in the lock/commit state stays hidden until a guarded write is tried. For that reason every guarded write is followed at once by a read-back of the register it could have changed. Pin faults show as a cause bit 0 that rises on the wrong edge, so it is checked both the edge before and the edge on which it must rise.

// File: rtl/nmi_agg_pkg.sv
package nmi_agg_pkg;
  localparam int NSRC = 7;

  localparam int SRC_PIN    = 0;
  localparam int SRC_OSC    = 1;
  localparam int SRC_SW     = 2;
  localparam int SRC_WDT    = 3;
  localparam int SRC_TAMPER = 4;
  localparam int SRC_BORA   = 5;
  localparam int SRC_BORD   = 6;

  typedef enum logic [1:0] {
    SEL_CAUSE  = 2'd0,
    SEL_LOCK   = 2'd1,
    SEL_COMMIT = 2'd2,
    SEL_PINCFG = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/nmi_sync.sv
module nmi_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], d_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/nmi_edge_det.sv
module nmi_edge_det #(
  parameter int N = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] level_i,
  output logic [N-1:0] rise_o
);
  logic [N-1:0] prev_q;

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q[i] <= 1'b0;
      else        prev_q[i] <= level_i[i];
    end
    assign rise_o[i] = level_i[i] & ~prev_q[i];
  end
endmodule

// File: rtl/nmi_lock_ctrl.sv
module nmi_lock_ctrl
  import nmi_agg_pkg::*;
#(
  parameter int          DW  = 32,
  parameter logic [DW-1:0] KEY = 32'hA5C3_1E7D
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_i,
  input  reg_sel_e      sel_i,
  input  logic [DW-1:0] wdata_i,
  output logic          locked_o,
  output logic          commit_o,
  output logic          pin_en_o
);
  logic locked_q, locked_d;
  logic commit_q, commit_d;
  logic pin_en_q, pin_en_d;

  always_comb begin
    locked_d = locked_q;
    commit_d = commit_q;
    pin_en_d = pin_en_q;
    if (wr_i) begin
      unique case (sel_i)
        SEL_LOCK:   locked_d = (wdata_i != KEY);
        SEL_COMMIT: if (!locked_q) commit_d = wdata_i[0];
        SEL_PINCFG: if (commit_q)  pin_en_d = wdata_i[0];
        default:    ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked_q <= 1'b1;
      commit_q <= 1'b0;
      pin_en_q <= 1'b0;
    end else begin
      locked_q <= locked_d;
      commit_q <= commit_d;
      pin_en_q <= pin_en_d;
    end
  end

  assign locked_o = locked_q;
  assign commit_o = commit_q;
  assign pin_en_o = pin_en_q;

  // R8: commit write ignored while locked
  a_r8_commit_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && sel_i == SEL_COMMIT && locked_q) |=> $stable(commit_q));
  // R8: a wrong key always leaves the block locked
  a_r8_relock: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && sel_i == SEL_LOCK && wdata_i != KEY) |=> locked_q);
  // R9: pin-enable write ignored without commit
  a_r9_pincfg_guard: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && sel_i == SEL_PINCFG && !commit_q) |=> $stable(pin_en_q));
endmodule

// File: rtl/nmi_cause_reg.sv
module nmi_cause_reg #(
  parameter int N = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] evt_i,
  input  logic         clr_wr_i,
  input  logic [N-1:0] clr_data_i,
  output logic [N-1:0] cause_o,
  output logic         nmi_o
);
  logic [N-1:0] cause_q, cause_d, keep_mask;

  always_comb begin
    keep_mask = clr_wr_i ? clr_data_i : {N{1'b1}};
    cause_d   = (cause_q & keep_mask) | evt_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cause_q <= '0;
    else        cause_q <= cause_d;
  end

  assign cause_o = cause_q;
  assign nmi_o   = |cause_q;

  // R2/R5: every event lands in its bit, whatever the clear did
  a_r5_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i != '0) |=> ((cause_q & $past(evt_i)) == $past(evt_i)));
  // R2: no bit appears without an event
  a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((cause_q & ~$past(cause_q) & ~$past(evt_i)) == '0));
  // R4: bits written with 0 and not re-triggered are cleared
  a_r4_w0c: assert property (@(posedge clk) disable iff (!rst_n)
    clr_wr_i |=> ((cause_q & ~$past(clr_data_i) & ~$past(evt_i)) == '0));
  // R3: request holds while no clearing write occurs
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_o && !clr_wr_i) |=> nmi_o);
endmodule

// File: rtl/nmi_aggregator.sv
module nmi_aggregator
  import nmi_agg_pkg::*;
#(
  parameter int            DW          = 32,
  parameter int            SYNC_STAGES = 2,
  parameter logic [DW-1:0] UNLOCK_KEY  = 32'hA5C3_1E7D
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pin_async_i,
  input  logic          osc_fail_i,
  input  logic          sw_nmi_i,
  input  logic          wdt_timeout_i,
  input  logic          wdt_nmi_mode_i,
  input  logic          tamper_i,
  input  logic          bor_analog_i,
  input  logic          bor_digital_i,
  input  logic          reg_wr_i,
  input  logic [1:0]    reg_sel_i,
  input  logic [DW-1:0] reg_wdata_i,
  output logic [DW-1:0] reg_rdata_o,
  output logic          nmi_o
);
  localparam int PAD = DW - NSRC;

  reg_sel_e     sel;
  logic         pin_sync;
  logic         locked, commit, pin_en;
  logic [NSRC-1:0] level, rise, cause;
  logic         cause_wr;

  assign sel = reg_sel_e'(reg_sel_i);

  nmi_sync #(.STAGES(SYNC_STAGES)) u_pin_sync (
    .clk(clk), .rst_n(rst_n), .d_i(pin_async_i), .q_o(pin_sync)
  );

  nmi_lock_ctrl #(.DW(DW), .KEY(UNLOCK_KEY)) u_lock (
    .clk(clk), .rst_n(rst_n), .wr_i(reg_wr_i), .sel_i(sel),
    .wdata_i(reg_wdata_i), .locked_o(locked), .commit_o(commit),
    .pin_en_o(pin_en)
  );

  always_comb begin
    level             = '0;
    level[SRC_PIN]    = pin_sync & pin_en;
    level[SRC_OSC]    = osc_fail_i;
    level[SRC_SW]     = sw_nmi_i;
    level[SRC_WDT]    = wdt_timeout_i & wdt_nmi_mode_i;
    level[SRC_TAMPER] = tamper_i;
    level[SRC_BORA]   = bor_analog_i;
    level[SRC_BORD]   = bor_digital_i;
  end

  nmi_edge_det #(.N(NSRC)) u_edge (
    .clk(clk), .rst_n(rst_n), .level_i(level), .rise_o(rise)
  );

  assign cause_wr = reg_wr_i && (sel == SEL_CAUSE);

  nmi_cause_reg #(.N(NSRC)) u_cause (
    .clk(clk), .rst_n(rst_n), .evt_i(rise), .clr_wr_i(cause_wr),
    .clr_data_i(reg_wdata_i[NSRC-1:0]), .cause_o(cause), .nmi_o(nmi_o)
  );

  always_comb begin
    unique case (sel)
      SEL_CAUSE:  reg_rdata_o = {{PAD{1'b0}}, cause};
      SEL_LOCK:   reg_rdata_o = {{(DW-1){1'b0}}, locked};
      SEL_COMMIT: reg_rdata_o = {{(DW-1){1'b0}}, commit};
      default:    reg_rdata_o = {{(DW-1){1'b0}}, pin_en};
    endcase
  end

  // R6: watchdog bit cannot rise while watchdog is not in NMI mode
  a_r6_wdt_mode: assert property (@(posedge clk) disable iff (!rst_n)
    (!cause[SRC_WDT] && !wdt_nmi_mode_i) |=> !cause[SRC_WDT]);
  // R7: pin bit cannot rise while the pin is disabled
  a_r7_pin_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (!cause[SRC_PIN] && !pin_en) |=> !cause[SRC_PIN]);
endmodule

// File: tb/nmi_aggregator_tb.sv
module nmi_aggregator_tb;
  localparam int DW = 32;
  localparam logic [31:0] KEY = 32'hA5C3_1E7D;

  typedef struct packed {
    logic [6:0] pre;
    logic [6:0] src;
    logic       wmode;
    logic       clr_en;
    logic [6:0] clr_data;
    logic [6:0] exp;
  } vec_t;

  // R2 R4 R5 R6 vectors: pre-set bits, then src edges with optional clear
  localparam vec_t VECS [8] = '{
    '{7'b0000000, 7'b0000010, 1'b0, 1'b0, 7'b0000000, 7'b0000010},
    '{7'b0000000, 7'b0001000, 1'b0, 1'b0, 7'b0000000, 7'b0000000},
    '{7'b0000000, 7'b0001000, 1'b1, 1'b0, 7'b0000000, 7'b0001000},
    '{7'b0110000, 7'b0000000, 1'b0, 1'b1, 7'b0100000, 7'b0100000},
    '{7'b1000100, 7'b0000100, 1'b0, 1'b1, 7'b0000000, 7'b0000100},
    '{7'b1111110, 7'b0000000, 1'b1, 1'b1, 7'b1010101, 7'b1010100},
    '{7'b0000000, 7'b1100000, 1'b0, 1'b0, 7'b0000000, 7'b1100000},
    '{7'b0011110, 7'b0000010, 1'b0, 1'b1, 7'b0000000, 7'b0000010}
  };

  logic clk = 1'b0;
  logic rst_n;
  logic pin, osc, sw, wdt, wmode, tamper, bora, bord;
  logic reg_wr;
  logic [1:0] reg_sel;
  logic [DW-1:0] reg_wdata, reg_rdata;
  logic nmi;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  nmi_aggregator #(.DW(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .pin_async_i(pin), .osc_fail_i(osc),
    .sw_nmi_i(sw), .wdt_timeout_i(wdt), .wdt_nmi_mode_i(wmode),
    .tamper_i(tamper), .bor_analog_i(bora), .bor_digital_i(bord),
    .reg_wr_i(reg_wr), .reg_sel_i(reg_sel), .reg_wdata_i(reg_wdata),
    .reg_rdata_o(reg_rdata), .nmi_o(nmi)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive_src(logic [6:0] m);
    osc = m[1]; sw = m[2]; wdt = m[3]; tamper = m[4]; bora = m[5]; bord = m[6];
  endtask

  task automatic reg_write(logic [1:0] s, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = s; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_sel = 2'd0;
  endtask

  task automatic reg_read(logic [1:0] s, output logic [31:0] d);
    reg_sel = s;
    #1;
    d = reg_rdata;
    reg_sel = 2'd0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin : stim
    logic [31:0] rd;
    rst_n = 1'b0; pin = 1'b0; wmode = 1'b0; reg_wr = 1'b0;
    reg_sel = 2'd0; reg_wdata = '0;
    drive_src(7'b0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state, R10 read map
    reg_read(2'd0, rd); check("R1 cause", rd, 32'd0);
    check("R1 nmi", {31'b0, nmi}, 32'd0);
    reg_read(2'd1, rd); check("R1 R10 locked", rd, 32'd1);
    reg_read(2'd2, rd); check("R1 commit", rd, 32'd0);
    reg_read(2'd3, rd); check("R1 pin_en", rd, 32'd0);

    // vector table
    for (int i = 0; i < 8; i++) begin
      wmode = VECS[i].wmode;
      reg_write(2'd0, 32'd0);
      drive_src(VECS[i].pre);
      @(negedge clk);
      drive_src(7'b0);
      @(negedge clk);
      drive_src(VECS[i].src);
      if (VECS[i].clr_en) begin
        reg_wr = 1'b1; reg_sel = 2'd0; reg_wdata = {25'b0, VECS[i].clr_data};
      end
      @(negedge clk);
      drive_src(7'b0);
      reg_wr = 1'b0;
      reg_read(2'd0, rd);
      check($sformatf("R2 R4 R5 R6 vec%0d cause", i), rd, {25'b0, VECS[i].exp});
      check($sformatf("R3 vec%0d nmi", i), {31'b0, nmi}, {31'b0, (VECS[i].exp != 0)});
    end
    wmode = 1'b0;
    reg_write(2'd0, 32'd0);

    // R3: nmi stays until every bit is cleared
    drive_src(7'b0010010);
    @(negedge clk);
    drive_src(7'b0);
    reg_write(2'd0, 32'h10);
    check("R3 nmi after partial clear", {31'b0, nmi}, 32'd1);
    reg_write(2'd0, 32'h0);
    check("R3 nmi after full clear", {31'b0, nmi}, 32'd0);

    // R2: held level does not re-set after clear
    drive_src(7'b0000100);
    @(negedge clk);
    reg_write(2'd0, 32'h0);
    repeat (2) @(negedge clk);
    reg_read(2'd0, rd); check("R2 held level no re-set", rd, 32'd0);
    drive_src(7'b0);

    // R7: pin ignored while disabled
    pin = 1'b1;
    repeat (5) @(negedge clk);
    reg_read(2'd0, rd); check("R7 pin disabled", rd, 32'd0);
    pin = 1'b0;

    // R9: pin-enable ignored without commit; R8 commit ignored while locked
    reg_write(2'd3, 32'd1);
    reg_read(2'd3, rd); check("R9 pincfg without commit", rd, 32'd0);
    reg_write(2'd2, 32'd1);
    reg_read(2'd2, rd); check("R8 commit while locked", rd, 32'd0);

    // R8 unlock, commit, enable
    reg_write(2'd1, KEY);
    reg_read(2'd1, rd); check("R8 unlocked", rd, 32'd0);
    reg_write(2'd2, 32'd1);
    reg_read(2'd2, rd); check("R8 commit accepted", rd, 32'd1);
    reg_write(2'd3, 32'd1);
    reg_read(2'd3, rd); check("R9 pincfg accepted", rd, 32'd1);

    // R8 relock on wrong key; commit write then ignored
    reg_write(2'd1, KEY ^ 32'h1);
    reg_read(2'd1, rd); check("R8 relocked", rd, 32'd1);
    reg_write(2'd2, 32'd0);
    reg_read(2'd2, rd); check("R8 commit held after relock", rd, 32'd1);

    // R7 pin latency: bit 0 sets on third edge after pin rises
    repeat (3) @(negedge clk);
    pin = 1'b1;
    repeat (2) @(negedge clk);
    reg_read(2'd0, rd); check("R7 pin before third edge", rd, 32'd0);
    @(negedge clk);
    reg_read(2'd0, rd); check("R7 pin on third edge", rd, 32'd1);
    check("R3 nmi from pin", {31'b0, nmi}, 32'd1);
    reg_write(2'd0, 32'd0);
    repeat (2) @(negedge clk);
    reg_read(2'd0, rd); check("R2 R7 pin held no re-set", rd, 32'd0);
    pin = 1'b0;

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule